// File: doc/BRIEF.md
# Instruction Cache Tag Directory

This block keeps the tags and replacement state of a set-associative instruction cache. It holds no instruction data. It answers one question for each fetch address: is the block already resident, and if not, which way it replaces. Every way of every set carries a small usage counter that saturates at zero. A hit or a fill sets that counter to its top value, and the other ways in the set count down, so the counters stand in for recency without a full ordering.

Commands reach the directory through three command registers that clear themselves: fetch, invalidate and lock. Writing a nonzero byte address into the fetch register starts a lookup. Writing one into the invalidate register removes the matching block. A per-way enable mask decides which ways age on a miss and which ways may be invalidated. The block counts hits and misses as they occur. Fetch lookups are gated by a cache-present input and a cache-enable input. Invalidates need only the present input.

Top module: `icache_tag_dir`

## Requirements
- R1: The set index is (byte address / BLOCK_BYTES) mod SETS and the tag is (byte address / BLOCK_BYTES) / SETS. Addresses in different sets never displace each other, and addresses in the same block hit the same entry.
- R2: On a fetch hit, the result reports hit=1 and the number of the matching way. Every nonzero usage counter in the set drops by one, and the hit way's counter is then set to USTATES-1.
- R3: On a fetch miss, the victim is the lowest-numbered way holding the smallest usage counter in the set. The victim takes the new tag, its counter goes to USTATES-1, and the result reports hit=0 with the victim way.
- R4: On a miss, a non-victim way's nonzero counter drops by one only when that way's bit in way_mask is 1.
- R5: An invalidate whose address matches a way with its way_mask bit set makes that way's tag invalid (all ones, one bit wider than any address tag). Otherwise the invalidate changes nothing.
- R6: A fetch has no effect and gives no result unless cache_present and cache_enable are both 1. An invalidate has no effect unless cache_present is 1.
- R7: wr_en bit 0 writes the fetch register, bit 1 the invalidate register and bit 2 the lock register, all from wr_addr. A nonzero value is processed and then cleared. The lock register clears on the next cycle with no other effect. A zero value does nothing. pending reports which registers are nonzero, using the same bit order.
- R8: When the fetch and invalidate registers are both nonzero, the fetch is processed first and the invalidate in the following cycle.
- R9: hit_count and miss_count each increase by one for every fetch hit and every fetch miss.
- R10: After reset, every tag is invalid, every usage counter is zero, both event counters are zero, no register is pending and res_valid is 0.
- R11: A lookup completes in one clock. res_valid pulses for one cycle, in the cycle after the fetch command is processed, and is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cache_present | input | 1 | Cache exists; needed by every command |
| cache_enable | input | 1 | Cache enabled; needed by fetch lookups |
| way_mask | input | WAYS | Per-way enable for aging on a miss and for invalidation |
| wr_en | input | 3 | Register write strobes: bit0 fetch, bit1 invalidate, bit2 lock |
| wr_addr | input | ADDR_W | Byte address written into the strobed registers |
| pending | output | 3 | Nonzero flags of the fetch, invalidate and lock registers |
| res_valid | output | 1 | One-cycle pulse: a lookup result is present |
| res_hit | output | 1 | 1 = hit, 0 = miss |
| res_way | output | WAYW | Way that hit, or the victim way on a miss |
| hit_count | output | CNT_W | Running count of hits |
| miss_count | output | CNT_W | Running count of misses |

## Verification
A fetch and an invalidate of the same address can both be pending in one cycle. The bench provokes this by setting bits 0 and 1 of wr_en together. It then checks that the fetch reports a hit on the still-valid way while the invalidate flag stays pending, that the invalidate flag drops one cycle later, and that a fetch of the same address then misses. The bench also sets cache_enable low while an invalidate is processed, to confirm that the invalidate still takes effect when fetches are gated off.

// File: rtl/icd_pkg.sv
package icd_pkg;
  localparam int WR_FETCH = 0;
  localparam int WR_INVAL = 1;
  localparam int WR_LOCK  = 2;

  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_FETCH = 2'd1,
    CMD_INVAL = 2'd2
  } icd_cmd_e;
endpackage

// File: rtl/icd_cmd_regs.sv
module icd_cmd_regs
  import icd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output icd_cmd_e          cmd_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [2:0]        pend_o
);
  logic [ADDR_W-1:0] fetch_q, inval_q, lock_q;

  // fetch register wins over invalidate register
  always_comb begin
    if (fetch_q != '0) begin
      cmd_o      = CMD_FETCH;
      cmd_addr_o = fetch_q;
    end else if (inval_q != '0) begin
      cmd_o      = CMD_INVAL;
      cmd_addr_o = inval_q;
    end else begin
      cmd_o      = CMD_IDLE;
      cmd_addr_o = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_q <= '0;
      inval_q <= '0;
      lock_q  <= '0;
    end else begin
      if (wr_en[WR_FETCH])         fetch_q <= wr_addr;
      else if (cmd_o == CMD_FETCH) fetch_q <= '0;
      if (wr_en[WR_INVAL])         inval_q <= wr_addr;
      else if (cmd_o == CMD_INVAL) inval_q <= '0;
      lock_q <= wr_en[WR_LOCK] ? wr_addr : '0;
    end
  end

  assign pend_o = {lock_q != '0, inval_q != '0, fetch_q != '0};

  p_fetch_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o[0] && !wr_en[WR_FETCH]) |=> !pend_o[0]);
  p_lock_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o[2] && !wr_en[WR_LOCK]) |=> !pend_o[2]);
  p_inval_waits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o[0] && pend_o[1]) |=> pend_o[1]);
endmodule

// File: rtl/icd_victim.sv
module icd_victim #(
  parameter int WAYS = 1,
  parameter int CW   = 1,
  localparam int WW  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS*CW-1:0] cnt_i,
  output logic [WW-1:0]      vic_o,
  output logic [WAYS-1:0]    vic_oh_o
);
  logic [CW-1:0] best;

  // lowest-numbered way holding the smallest counter
  always_comb begin
    best  = cnt_i[CW-1:0];
    vic_o = '0;
    for (int w = 1; w < WAYS; w++) begin
      if (cnt_i[w*CW +: CW] < best) begin
        best  = cnt_i[w*CW +: CW];
        vic_o = WW'(w);
      end
    end
    for (int w = 0; w < WAYS; w++) vic_oh_o[w] = (vic_o == WW'(w));
  end
endmodule

// File: rtl/icache_tag_dir.sv
module icache_tag_dir
  import icd_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int SETS        = 512,
  parameter int BLOCK_BYTES = 16,
  parameter int WAYS        = 1,
  parameter int USTATES     = 2,
  parameter int CNT_W       = 32,
  localparam int WAYW       = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cache_present,
  input  logic              cache_enable,
  input  logic [WAYS-1:0]   way_mask,
  input  logic [2:0]        wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [2:0]        pending,
  output logic              res_valid,
  output logic              res_hit,
  output logic [WAYW-1:0]   res_way,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);
  localparam int OFF_W = $clog2(BLOCK_BYTES);
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam int STW   = TAG_W + 1;
  localparam int CW    = (USTATES > 1) ? $clog2(USTATES) : 1;
  localparam logic [CW-1:0] CMAX = CW'(USTATES - 1);

  function automatic logic [IDX_W-1:0] set_of(input logic [ADDR_W-1:0] a);
    return IDX_W'((a / BLOCK_BYTES) % SETS);
  endfunction

  function automatic logic [STW-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return STW'((a / BLOCK_BYTES) / SETS);
  endfunction

  function automatic logic [CW-1:0] age(input logic [CW-1:0] c);
    return (c == '0) ? c : c - 1'b1;
  endfunction

  icd_cmd_e          cmd;
  logic [ADDR_W-1:0] cmd_addr;

  icd_cmd_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .cmd_o(cmd), .cmd_addr_o(cmd_addr), .pend_o(pending)
  );

  logic [STW-1:0] tag_q [SETS][WAYS];
  logic [CW-1:0]  cnt_q [SETS][WAYS];

  logic [IDX_W-1:0]   idx;
  logic [STW-1:0]     atag;
  logic [WAYS-1:0]    match, first_oh, vic_oh;
  logic [WAYS*CW-1:0] set_cnt;
  logic [WAYW-1:0]    hit_way, vic_way;
  logic               any_match, found;

  assign idx  = set_of(cmd_addr);
  assign atag = tag_of(cmd_addr);

  always_comb begin
    found   = 1'b0;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      match[w]            = (tag_q[idx][w] == atag);
      first_oh[w]         = match[w] && !found;
      found               = found | match[w];
      set_cnt[w*CW +: CW] = cnt_q[idx][w];
      if (first_oh[w]) hit_way = WAYW'(w);
    end
    any_match = found;
  end

  icd_victim #(.WAYS(WAYS), .CW(CW)) u_vic (
    .cnt_i(set_cnt), .vic_o(vic_way), .vic_oh_o(vic_oh)
  );

  // named events for the assertions
  logic fetch_go, inval_go, ev_hit, ev_miss, ev_kill;
  assign fetch_go = (cmd == CMD_FETCH) && cache_present && cache_enable;
  assign inval_go = (cmd == CMD_INVAL) && cache_present;
  assign ev_hit   = fetch_go && any_match;
  assign ev_miss  = fetch_go && !any_match;
  assign ev_kill  = inval_go && ((first_oh & way_mask) != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          tag_q[s][w] <= '1;
          cnt_q[s][w] <= '0;
        end
    end else begin
      for (int w = 0; w < WAYS; w++) begin
        if (ev_hit) begin
          cnt_q[idx][w] <= first_oh[w] ? CMAX : age(cnt_q[idx][w]);
        end else if (ev_miss) begin
          if (vic_oh[w]) begin
            tag_q[idx][w] <= atag;
            cnt_q[idx][w] <= CMAX;
          end else if (way_mask[w]) begin
            cnt_q[idx][w] <= age(cnt_q[idx][w]);
          end
        end
        if (ev_kill && first_oh[w] && way_mask[w]) tag_q[idx][w] <= '1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_hit    <= 1'b0;
      res_way    <= '0;
      hit_count  <= '0;
      miss_count <= '0;
    end else begin
      res_valid <= fetch_go;
      if (fetch_go) begin
        res_hit <= any_match;
        res_way <= any_match ? hit_way : vic_way;
      end
      if (ev_hit)  hit_count  <= hit_count + 1'b1;
      if (ev_miss) miss_count <= miss_count + 1'b1;
    end
  end

  p_hit_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit |=> (hit_count == CNT_W'($past(hit_count) + 1'b1)));
  p_miss_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_miss |=> (miss_count == CNT_W'($past(miss_count) + 1'b1)));
  p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd == CMD_FETCH) && !(cache_present && cache_enable)) |=> !res_valid);
  p_one_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != CMD_FETCH) |=> !res_valid);
  p_hit_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit |=> (res_valid && res_hit));

  for (genvar g = 0; g < WAYS; g++) begin : g_vchk
    p_victim_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ev_miss |-> (set_cnt[vic_way*CW +: CW] <= set_cnt[g*CW +: CW]));
  end
endmodule

// File: tb/sim_icache_tag_dir.sv
module sim_icache_tag_dir;
  localparam int AW = 16;
  localparam int NV = 13;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          present, enable;
  logic [3:0]    mask;
  logic [2:0]    wr_en;
  logic [AW-1:0] wr_addr;
  logic [2:0]    pending;
  logic          res_valid, res_hit;
  logic [1:0]    res_way;
  logic [15:0]   hit_count, miss_count;

  int checks = 0, fails = 0, eh = 0, em = 0;

  always #5 clk = ~clk;

  icache_tag_dir #(.ADDR_W(AW), .SETS(4), .BLOCK_BYTES(16), .WAYS(4),
                   .USTATES(4), .CNT_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .cache_present(present), .cache_enable(enable),
    .way_mask(mask), .wr_en(wr_en), .wr_addr(wr_addr), .pending(pending),
    .res_valid(res_valid), .res_hit(res_hit), .res_way(res_way),
    .hit_count(hit_count), .miss_count(miss_count)
  );

  // {wr_en, addr, expect_valid, expect_hit, expect_way}; set 0 tag N = N*64
  localparam logic [22:0] VEC [NV] = '{
    {3'b001, 16'h0040, 1'b1, 1'b0, 2'd0},  // R10 first miss fills way 0
    {3'b001, 16'h0080, 1'b1, 1'b0, 2'd1},  // R3
    {3'b001, 16'h00C0, 1'b1, 1'b0, 2'd2},  // R3
    {3'b001, 16'h0044, 1'b1, 1'b1, 2'd0},  // R1 same block, R2 hit
    {3'b001, 16'h0100, 1'b1, 1'b0, 2'd3},  // R3
    {3'b001, 16'h0140, 1'b1, 1'b0, 2'd1},  // R2 aging evicts way 1
    {3'b001, 16'h0080, 1'b1, 1'b0, 2'd2},  // R3
    {3'b001, 16'h00C0, 1'b1, 1'b0, 2'd0},  // R3
    {3'b001, 16'h0150, 1'b1, 1'b0, 2'd0},  // R1 set 1 is separate
    {3'b001, 16'h0108, 1'b1, 1'b1, 2'd3},  // R1 set 0 untouched, R2
    {3'b010, 16'h00C0, 1'b0, 1'b0, 2'd0},  // R5 kill way 0
    {3'b001, 16'h00C0, 1'b1, 1'b0, 2'd1},  // R5 now misses
    {3'b001, 16'h0080, 1'b1, 1'b1, 2'd2}   // R2
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = '0; wr_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; eh = 0; em = 0;
    @(negedge clk);
  endtask

  // write, then sample at the negedge after the processing edge
  task automatic cmd(input logic [2:0] en, input logic [AW-1:0] a);
    wr_en = en; wr_addr = a;
    @(negedge clk);
    wr_en = '0;
    chk("R11 no early result", {31'd0, res_valid}, 32'd0);
    @(negedge clk);
  endtask

  task automatic expect_res(input string req, input logic v, input logic h, input logic [1:0] w);
    chk(req, {31'd0, res_valid}, {31'd0, v});
    if (v) begin
      chk(req, {31'd0, res_hit}, {31'd0, h});
      chk(req, {30'd0, res_way}, {30'd0, w});
      if (h) eh++; else em++;
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    present = 1'b1; enable = 1'b1; mask = 4'b1111;
    do_reset();
    chk("R10 hit_count", {16'd0, hit_count}, 32'd0);
    chk("R10 miss_count", {16'd0, miss_count}, 32'd0);
    chk("R10 pending", {29'd0, pending}, 32'd0);
    chk("R10 res_valid", {31'd0, res_valid}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      cmd(VEC[i][22:20], VEC[i][19:4]);
      expect_res("R1/R2/R3/R5 table", VEC[i][3], VEC[i][2], VEC[i][1:0]);
    end
    chk("R9 hits", {16'd0, hit_count}, eh);
    chk("R9 misses", {16'd0, miss_count}, em);

    // R4: only way 0 ages on a miss
    do_reset();
    mask = 4'b0001;
    cmd(3'b001, 16'h0040); expect_res("R4", 1, 0, 0);
    cmd(3'b001, 16'h0080); expect_res("R4", 1, 0, 1);
    cmd(3'b001, 16'h00C0); expect_res("R4", 1, 0, 2);
    cmd(3'b001, 16'h0100); expect_res("R4", 1, 0, 3);
    cmd(3'b001, 16'h0140); expect_res("R4", 1, 0, 0);
    cmd(3'b001, 16'h0180); expect_res("R4 masked ways hold", 1, 0, 0);

    // R5: mask bit clear blocks invalidate, set bit allows it
    cmd(3'b010, 16'h0080); expect_res("R5 no result", 0, 0, 0);
    cmd(3'b001, 16'h0080); expect_res("R5 masked way kept", 1, 1, 1);
    cmd(3'b010, 16'h0180);
    cmd(3'b001, 16'h0180); expect_res("R5 enabled way killed", 1, 0, 0);

    // R6: gating
    mask = 4'b1111;
    enable = 1'b0;
    cmd(3'b001, 16'h0080); expect_res("R6 fetch gated", 0, 0, 0);
    chk("R6 fetch reg cleared", {29'd0, pending}, 32'd0);
    enable = 1'b1; present = 1'b0;
    cmd(3'b010, 16'h0080);
    present = 1'b1;
    cmd(3'b001, 16'h0080); expect_res("R6 inval gated by present", 1, 1, 1);
    enable = 1'b0;
    cmd(3'b010, 16'h00C0);
    enable = 1'b1;
    cmd(3'b001, 16'h00C0); expect_res("R6 inval works without enable", 1, 0, 2);

    // R8: both registers pending at once
    wr_en = 3'b011; wr_addr = 16'h00C0;
    @(negedge clk); wr_en = '0;
    chk("R8 both pending", {29'd0, pending}, 32'd3);
    @(negedge clk);
    expect_res("R8 fetch first", 1, 1, 2);
    chk("R8 inval still pending", {29'd0, pending}, 32'd2);
    @(negedge clk);
    chk("R8 inval done", {29'd0, pending}, 32'd0);
    chk("R11 single pulse", {31'd0, res_valid}, 32'd0);
    cmd(3'b001, 16'h00C0); expect_res("R8 inval applied", 1, 0, 0);

    // R7: zero write and lock register
    cmd(3'b001, 16'h0000); expect_res("R7 zero write idle", 0, 0, 0);
    wr_en = 3'b100; wr_addr = 16'h0055;
    @(negedge clk); wr_en = '0;
    chk("R7 lock pending", {29'd0, pending}, 32'd4);
    @(negedge clk);
    chk("R7 lock cleared", {29'd0, pending}, 32'd0);
    chk("R7 lock no result", {31'd0, res_valid}, 32'd0);

    chk("R9 hits", {16'd0, hit_count}, eh);
    chk("R9 misses", {16'd0, miss_count}, em);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule